// File: doc/BRIEF.md
# Double-Buffered DAC Register Front End

This block is the digital side of a multi-channel 8-bit converter interface. Every channel keeps two code registers. The first is an input register, loaded from a shared write bus. The second is a DAC register, whose contents form the code sent to that channel's converter. A small decoder turns the bus address and write strobe into a chip-select for each channel and one broadcast transfer strobe. A host can therefore stage new codes channel by channel and then commit all of them with a single write to the transfer address.

The strobes in this model are level-actuated, and they are sampled on a clock. A stage whose enable combination is asserted in a cycle copies its source at the next edge, so a transparent path appears with a one-cycle delay per stage. A mode input can hold the second-stage controls asserted, which gives single-buffered use. It can also hold every control asserted, which gives flow-through use. Data bits the bus does not drive are read as ones.

Top module: `dbdac_frontend`

## Requirements
- R1: While reset is asserted, and after it is released, every input register and every DAC code is 0x00 until a load happens.
- R2: In double-buffered mode (`buf_mode` = 2'b00), a bus write (`bus_wr` = 1) to address i (i < NUM_CH) with `ile` = 1 loads the input register of channel i at the next edge. The value loaded is the resolved bus data.
- R3: A bus write made while `ile` = 0 leaves every input register unchanged.
- R4: A write to address i changes no other channel. A write to an address that is neither a channel nor the transfer address changes nothing.
- R5: A bus write to the transfer address (15 by default) copies the input register of every channel into its DAC register. The new codes appear on `dac_code` one cycle later.
- R6: Without a transfer, each DAC code holds its value in double-buffered mode, even when its input register is rewritten.
- R7: After a transfer, a channel whose input register was not written since the previous transfer presents the same code as before.
- R8: Each bus data bit whose `bus_drv` bit is 0 is read as 1.
- R9: In single-buffered mode (`buf_mode` = 2'b01), a write to channel i shows on that channel's code two cycles after the write cycle, with no transfer. The other channels keep their codes.
- R10: In flow-through mode (`buf_mode` = 2'b10), every channel's code equals the resolved bus data from two cycles earlier. In this mode the address, write strobe and `ile` have no effect.
- R11: Bus bit 0 is the code LSB and bus bit 7 is the code MSB. Channel i occupies bits [8i+7:8i] of `dac_code`. `buf_mode` = 2'b11 behaves like double-buffered mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| buf_mode | input | 2 | 00 double, 01 single, 10 flow-through, 11 as double |
| bus_addr | input | ADDR_W | Write address: a channel index or the transfer address |
| bus_wr | input | 1 | Write strobe, active high |
| bus_data | input | DATA_W | Write data |
| bus_drv | input | DATA_W | Per-bit driven flag; 0 means the bit floats and reads as 1 |
| ile | input | 1 | Shared input-enable; qualifies the first-stage write |
| dac_code | output | NUM_CH*DATA_W | DAC register codes, channel 0 in the low byte |

## Verification
The hardest situation to reach is a transfer in which some channels hold freshly staged data and others hold stale data. A channel left untouched must keep its code, and so must a channel whose write was rejected because `ile` was low or because the address was wrong. The stimulus stages codes into a subset of the channels, sends deliberately blocked writes, and only then issues the broadcast transfer. It compares every channel against a bench model of both register stages. Mode changes are exercised with the bus held steady across the switch, so that the two-cycle pipeline of flow-through use can be told apart from the hold behaviour.

// File: rtl/dbdac_pkg.sv
package dbdac_pkg;

  typedef enum logic [1:0] {
    BUF_DOUBLE = 2'b00,
    BUF_SINGLE = 2'b01,
    BUF_FLOW   = 2'b10,
    BUF_RSVD   = 2'b11
  } buf_mode_e;

  // Second-stage controls are held asserted in single and flow modes.
  function automatic logic mode_holds_stage2(input buf_mode_e m);
    return (m == BUF_SINGLE) || (m == BUF_FLOW);
  endfunction

  // First-stage controls are held asserted only in flow mode.
  function automatic logic mode_holds_stage1(input buf_mode_e m);
    return (m == BUF_FLOW);
  endfunction

endpackage

// File: rtl/dbdac_bus_pull.sv
module dbdac_bus_pull #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] raw,
  input  logic [DATA_W-1:0] drv,
  output logic [DATA_W-1:0] resolved
);

  // A bit that is not driven resolves to a default-high level.
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign resolved[b] = drv[b] ? raw[b] : 1'b1;
  end

endmodule

// File: rtl/dbdac_decoder.sv
module dbdac_decoder #(
  parameter int NUM_CH    = 4,
  parameter int ADDR_W    = 4,
  parameter int XFER_ADDR = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  output logic [NUM_CH-1:0] cs_n,
  output logic              wr1_n,
  output logic              wr2_n,
  output logic              xfer_n
);

  localparam logic [ADDR_W-1:0] XferA = ADDR_W'(XFER_ADDR);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_cs
    assign cs_n[i] = ~(bus_wr && (bus_addr == ADDR_W'(i)));
  end

  assign xfer_n = ~(bus_wr && (bus_addr == XferA));
  assign wr1_n  = ~bus_wr;
  assign wr2_n  = ~bus_wr;

  // At most one channel is selected by any write.
  assert_cs_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // The transfer address never selects a channel.
  assert_xfer_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_n |-> (cs_n == '1));

  // Without a write strobe, nothing is selected.
  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |-> (xfer_n && (cs_n == '1)));

endmodule

// File: rtl/dbdac_input_stage.sv
module dbdac_input_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ile,
  input  logic              wr1_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q,
  output logic              load
);

  assign load = !cs_n && ile && !wr1_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din;
  end

  assert_in_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(din)));

  assert_in_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));

  assert_in_reset_R1: assert property (@(posedge clk)
    (!rst_n && $past(!rst_n)) |-> (q == '0));

endmodule

// File: rtl/dbdac_dac_stage.sv
module dbdac_dac_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr2_n,
  input  logic              xfer_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] code,
  output logic              load
);

  assign load = !wr2_n && !xfer_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    code <= '0;
    else if (load) code <= din;
  end

  assert_dac_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (code == $past(din)));

  assert_dac_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(code));

  assert_dac_reset_R1: assert property (@(posedge clk)
    (!rst_n && $past(!rst_n)) |-> (code == '0));

endmodule

// File: rtl/dbdac_frontend.sv
module dbdac_frontend
  import dbdac_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 4,
  parameter int XFER_ADDR = 15
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               buf_mode,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wr,
  input  logic [DATA_W-1:0]        bus_data,
  input  logic [DATA_W-1:0]        bus_drv,
  input  logic                     ile,
  output logic [NUM_CH*DATA_W-1:0] dac_code
);

  buf_mode_e                      mode_e;
  logic                           hold1, hold2;
  logic [DATA_W-1:0]              bus_resolved;
  logic [NUM_CH-1:0]              dec_cs_n;
  logic                           dec_wr1_n, dec_wr2_n, dec_xfer_n;
  logic                           eff_ile, eff_wr1_n, eff_wr2_n, eff_xfer_n;
  logic [NUM_CH-1:0]              eff_cs_n;
  logic [NUM_CH-1:0][DATA_W-1:0]  inp_q, code_q;
  logic [NUM_CH-1:0]              inp_load, dac_load;
  logic                           xfer_evt;

  assign mode_e = buf_mode_e'(buf_mode);
  assign hold1  = mode_holds_stage1(mode_e);
  assign hold2  = mode_holds_stage2(mode_e);

  dbdac_bus_pull #(.DATA_W(DATA_W)) u_pull (
    .raw      (bus_data),
    .drv      (bus_drv),
    .resolved (bus_resolved)
  );

  dbdac_decoder #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .XFER_ADDR(XFER_ADDR)
  ) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .cs_n     (dec_cs_n),
    .wr1_n    (dec_wr1_n),
    .wr2_n    (dec_wr2_n),
    .xfer_n   (dec_xfer_n)
  );

  // Mode overrides pin the strobes to their asserted levels.
  assign eff_cs_n   = hold1 ? '0 : dec_cs_n;
  assign eff_ile    = hold1 | ile;
  assign eff_wr1_n  = hold1 ? 1'b0 : dec_wr1_n;
  assign eff_wr2_n  = hold2 ? 1'b0 : dec_wr2_n;
  assign eff_xfer_n = hold2 ? 1'b0 : dec_xfer_n;
  assign xfer_evt   = !dec_wr2_n && !dec_xfer_n;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    dbdac_input_stage #(.DATA_W(DATA_W)) u_in (
      .clk   (clk),
      .rst_n (rst_n),
      .cs_n  (eff_cs_n[i]),
      .ile   (eff_ile),
      .wr1_n (eff_wr1_n),
      .din   (bus_resolved),
      .q     (inp_q[i]),
      .load  (inp_load[i])
    );

    dbdac_dac_stage #(.DATA_W(DATA_W)) u_dac (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr2_n  (eff_wr2_n),
      .xfer_n (eff_xfer_n),
      .din    (inp_q[i]),
      .code   (code_q[i]),
      .load   (dac_load[i])
    );

    assign dac_code[i*DATA_W +: DATA_W] = code_q[i];
  end

  // Counts edges since reset, saturating, so the assertions below never look back into reset.
  logic [1:0] warm_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_cnt <= '0;
    else if (warm_cnt != 2'd3) warm_cnt <= warm_cnt + 2'd1;
  end

  assert_bcast_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_evt && !hold2) |=> (code_q == $past(inp_q)));

  assert_ile_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ile && !hold1) |=> $stable(inp_q));

  assert_flow_pipe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold1 && $past(hold1) && $past(hold1, 2) && warm_cnt == 2'd3)
      |-> (code_q[0] == $past(bus_resolved, 2)));

  assert_load_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !hold1 |-> $onehot0(inp_load));

endmodule

// File: tb/dbdac_frontend_tb.sv
`timescale 1ns/1ps
module dbdac_frontend_tb;

  localparam int NCH = 4;
  localparam int DW  = 8;
  localparam int AW  = 4;
  localparam int XA  = 15;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      buf_mode = 2'b00;
  logic [AW-1:0]   bus_addr = '0;
  logic            bus_wr = 1'b0;
  logic [DW-1:0]   bus_data = '0;
  logic [DW-1:0]   bus_drv = '1;
  logic            ile = 1'b1;
  logic [NCH*DW-1:0] dac_code;

  always #2.5 clk = ~clk;

  dbdac_frontend #(.NUM_CH(NCH), .DATA_W(DW), .ADDR_W(AW), .XFER_ADDR(XA)) u_dut (
    .clk(clk), .rst_n(rst_n), .buf_mode(buf_mode), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_data(bus_data), .bus_drv(bus_drv), .ile(ile),
    .dac_code(dac_code)
  );

  typedef struct {
    int          due;
    int          ch;
    logic [7:0]  exp;
    string       tag;
  } item_t;

  item_t      sb_q[$];
  int         cyc = 0;
  int         checks = 0;
  int         errors = 0;
  bit         done = 0;
  logic [7:0] m_inp [NCH];
  logic [7:0] m_dac [NCH];
  int         cur_mode = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] pull(input logic [7:0] d, input logic [7:0] drv);
    logic [7:0] r;
    for (int b = 0; b < 8; b++) r[b] = drv[b] ? d[b] : 1'b1;
    return r;
  endfunction

  task automatic push(input int due, input int ch, input logic [7:0] v, input string tag);
    item_t it;
    it.due = due; it.ch = ch; it.exp = v; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: compares each expected item in the cycle it falls due.
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      item_t it;
      logic [7:0] act;
      it  = sb_q.pop_front();
      act = dac_code[it.ch*DW +: DW];
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s ch%0d cyc%0d: actual %02h expected %02h",
                 it.tag, it.ch, cyc, act, it.exp);
      end
    end
  end

  task automatic check_all(input string tag);
    @(negedge clk);
    for (int c = 0; c < NCH; c++) push(cyc + 1, c, m_dac[c], tag);
    @(negedge clk);
  endtask

  task automatic do_write(input int addr, input logic [7:0] d, input logic [7:0] drv,
                          input logic ile_v);
    logic [7:0] r;
    @(negedge clk);
    bus_addr = AW'(addr); bus_data = d; bus_drv = drv; ile = ile_v; bus_wr = 1'b1;
    r = pull(d, drv);
    if (addr < NCH && ile_v) begin
      m_inp[addr] = r;
      if (cur_mode == 1) begin
        m_dac[addr] = r;
        push(cyc + 2, addr, r, "R9");
      end
    end
    @(negedge clk);
    bus_wr = 1'b0; ile = 1'b1; bus_drv = '1;
  endtask

  task automatic do_xfer(input string tag);
    @(negedge clk);
    bus_addr = AW'(XA); bus_wr = 1'b1;
    for (int c = 0; c < NCH; c++) begin
      m_dac[c] = m_inp[c];
      push(cyc + 1, c, m_dac[c], tag);
    end
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic set_mode(input int m);
    @(negedge clk);
    buf_mode = 2'(m); cur_mode = m;
    if (m == 1) for (int c = 0; c < NCH; c++) m_dac[c] = m_inp[c];
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic flow_step(input logic [7:0] d, input logic [7:0] drv);
    logic [7:0] r;
    @(negedge clk);
    bus_data = d; bus_drv = drv; bus_wr = 1'b0; ile = 1'b0;
    bus_addr = AW'(5);
    r = pull(d, drv);
    for (int c = 0; c < NCH; c++) begin
      m_inp[c] = r; m_dac[c] = r;
      push(cyc + 2, c, r, "R10");
    end
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin m_inp[c] = '0; m_dac[c] = '0; end
    repeat (3) @(negedge clk);
    for (int c = 0; c < NCH; c++) push(cyc + 1, c, 8'h00, "R1");
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check_all("R1");

    // R2/R11: stage two channels, then confirm the outputs still hold (R6).
    do_write(0, 8'hA5, 8'hFF, 1'b1);
    do_write(1, 8'h01, 8'hFF, 1'b1);
    check_all("R6");
    do_xfer("R5");            // also covers R2 and R11
    check_all("R11");

    // R7: only ch2 is written; the others must present their old codes.
    do_write(2, 8'h3C, 8'hFF, 1'b1);
    do_xfer("R7");

    // R3: write blocked by ile low.
    do_write(3, 8'h77, 8'hFF, 1'b0);
    do_xfer("R3");

    // R4: a stray address, then a write to ch1 that must not touch ch0.
    do_write(5, 8'hFF, 8'hFF, 1'b1);
    do_xfer("R4");
    do_write(1, 8'h10, 8'hFF, 1'b1);
    do_xfer("R4");

    // R8: the high nibble floats and must read as ones.
    do_write(0, 8'h00, 8'h0F, 1'b1);
    do_write(3, 8'h05, 8'hF0, 1'b1);
    do_xfer("R8");

    // R6: rewrite an input register without a transfer.
    do_write(2, 8'hEE, 8'hFF, 1'b1);
    check_all("R6");

    // R9: single-buffered mode.
    set_mode(1);
    check_all("R9");
    do_write(3, 8'h5A, 8'hFF, 1'b1);
    do_write(1, 8'hC3, 8'hFF, 1'b1);
    check_all("R9");

    // R10: flow-through mode.
    set_mode(2);
    flow_step(8'h12, 8'hFF);
    flow_step(8'h34, 8'hFF);
    flow_step(8'h80, 8'hF0);
    flow_step(8'h80, 8'hF0);
    flow_step(8'h80, 8'hF0);

    // Back to double-buffered mode: staged data must not show until a transfer.
    set_mode(0);
    ile = 1'b1;
    do_write(0, 8'h44, 8'hFF, 1'b1);
    check_all("R6");
    do_xfer("R5");

    // R11: the reserved mode code behaves like double-buffered mode.
    set_mode(3);
    do_write(2, 8'h99, 8'hFF, 1'b1);
    check_all("R11");
    do_xfer("R11");

    wait (sb_q.size() == 0);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule